// File: doc/BRIEF.md
# Programmable Sum-of-Products Output Cell

This block is one output cell of a small programmable logic array. A configuration vector plays the part of the fuse map. From the true and complement forms of a shared input bus it builds eight AND terms. Four of them are data terms whose OR is either the next register value or the output value itself. The other four control the cell: one sets the register, one clears it, one clocks it and one enables the output driver. That driver is also gated by an external enable shared by every cell.

The cell drives a tri-state pin model, given as a value plus an enable. It returns a feedback bit for the input bus of the array. An active-low preload input loads the register from the level on its own pin. Output polarity is a configuration bit of the cell. Registered or combinatorial operation follows from the set and clear terms: when both are true, the output bypasses the register.

Inside a synchronous chip, every register action happens on the system clock. The clock term is sampled and acts on its edge. The set and clear terms act on the next system clock edge.

Top module: `mc_cell`

## Requirements
- R1: The fuse vector holds 2*N_IN bits per term, with the terms in this order: data 0..N_DATA-1, set, clear, clock, enable. Within a term, bit 2i connects input i in true form and bit 2i+1 connects it in complement form. A term is the AND of its connected literals. With every literal connected it is constant 0, and with none connected it is constant 1.
- R2: The data value is the OR of the N_DATA data terms.
- R3: While the set and clear terms are both 1, the output follows the data value in the same cycle, with polarity applied, and does not show the register.
- R4: On a system clock edge at which the clock term is 1 and was 0 at the previous edge, the register loads the data value. At any other edge it does not load the data value.
- R5: At a system clock edge where only the set term is 1, the register becomes 1. Where only the clear term is 1, it becomes 0. Both take priority over the clock term.
- R6: With cfg_pol = 1 the pin value equals the selected value (register or data). With cfg_pol = 0 it is the inverse.
- R7: pin_oe is 1 only when the enable term is 1 and oe_pin_n is 0.
- R8: fb equals pin_out while pin_oe is 1, and equals pin_in otherwise.
- R9: At an edge with preload_n = 0, the register loads pin_in (inverted when cfg_pol = 0), so the driven pin then shows the level that was on pin_in. Preload takes priority over set, clear and clock.
- R10: While rst_n is 0 the register is 0, so the pin reads 1 with cfg_pol = 0 and 0 with cfg_pol = 1.
- R11: At an edge where the set and clear terms are both 1, the register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-up reset, asynchronous |
| cfg_fuse | input | FUSE_W | Fuse map, 2*N_IN bits per term |
| cfg_pol | input | 1 | Output polarity, 1 = true output |
| in_bus | input | N_IN | Shared array inputs (dedicated pins and feedback) |
| preload_n | input | 1 | Active-low register preload from pin |
| oe_pin_n | input | 1 | Shared active-low external output enable |
| pin_in | input | 1 | Level present on the pin |
| pin_out | output | 1 | Value driven onto the pin |
| pin_oe | output | 1 | Pin driver enable |
| fb | output | 1 | Feedback bit to the input bus |

## Verification
The combinatorial results are due in the same cycle as the input change that causes them, with no clock edge in between. These are pin_out in bypass mode, pin_oe and fb, and the bench samples them one nanosecond after driving. Register results are due one system edge after the cycle in which the stimulus was presented: load, set, clear, hold and preload. The bench drives on the falling edge and samples on the next falling edge, so exactly one rising edge lies between stimulus and check. Edge detection on the clock term is checked by holding that term high across several edges and confirming that only the first one loads.

// File: rtl/mc_pkg.sv
`timescale 1ns/1ps
package mc_pkg;
   // control terms follow the data terms in the fuse map, in this order
   localparam int unsigned N_CTL = 4;
   localparam int unsigned C_SET = 0;
   localparam int unsigned C_CLR = 1;
   localparam int unsigned C_CLK = 2;
   localparam int unsigned C_OE  = 3;
endpackage

// File: rtl/mc_pterm.sv
`timescale 1ns/1ps
// one programmable AND term over true/complement literals
module mc_pterm #(
   parameter int unsigned N_IN = 4
) (
   input  logic [2*N_IN-1:0] fuse_row,
   input  logic [N_IN-1:0]   lits,
   output logic              term
);
   logic [N_IN-1:0] miss;

   for (genvar i = 0; i < N_IN; i++) begin : g_lit
      // a connected literal that is false kills the term
      assign miss[i] = (fuse_row[2*i] & ~lits[i]) | (fuse_row[2*i+1] & lits[i]);
   end

   assign term = ~|miss;
endmodule

// File: rtl/mc_array.sv
`timescale 1ns/1ps
// product-term array of one cell: data OR plus control terms
module mc_array #(
   parameter int unsigned N_IN   = 4,
   parameter int unsigned N_DATA = 4
) (
   input  logic [(N_DATA+mc_pkg::N_CTL)*2*N_IN-1:0] fuse,
   input  logic [N_IN-1:0]                          lits,
   output logic                                     sum,
   output logic [mc_pkg::N_CTL-1:0]                 ctl
);
   localparam int unsigned ROW_W = 2 * N_IN;
   localparam int unsigned N_T   = N_DATA + mc_pkg::N_CTL;

   logic [N_T-1:0] terms;

   for (genvar t = 0; t < N_T; t++) begin : g_term
      mc_pterm #(.N_IN(N_IN)) u_pt (
         .fuse_row (fuse[t*ROW_W +: ROW_W]),
         .lits     (lits),
         .term     (terms[t])
      );
   end

   assign sum = |terms[N_DATA-1:0];
   assign ctl = terms[N_T-1:N_DATA];
endmodule

// File: rtl/mc_state.sv
`timescale 1ns/1ps
// cell register: preload, set, clear, hold, edge-triggered load
module mc_state #(
   parameter bit CK_RISE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   input  logic set_t,
   input  logic clr_t,
   input  logic ck_t,
   input  logic preload_n,
   input  logic pl_val,
   output logic q
);
   logic ck_prev;
   logic ck_fire;

   if (CK_RISE) begin : g_rise
      assign ck_fire = ck_t & ~ck_prev;
   end else begin : g_fall
      assign ck_fire = ~ck_t & ck_prev;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q       <= 1'b0;
         ck_prev <= 1'b0;
      end else begin
         ck_prev <= ck_t;
         if (!preload_n)              q <= pl_val;
         else if (set_t && clr_t)     q <= q;
         else if (set_t)              q <= 1'b1;
         else if (clr_t)              q <= 1'b0;
         else if (ck_fire)            q <= d;
      end
   end
endmodule

// File: rtl/mc_outpath.sv
`timescale 1ns/1ps
// output select, polarity, driver enable, feedback, preload source
module mc_outpath (
   input  logic cfg_pol,
   input  logic bypass,
   input  logic sum,
   input  logic q,
   input  logic oe_t,
   input  logic oe_pin_n,
   input  logic pin_in,
   output logic pin_out,
   output logic pin_oe,
   output logic fb,
   output logic pl_val
);
   logic sel;

   assign sel     = bypass ? sum : q;
   assign pin_out = cfg_pol ? sel : ~sel;
   assign pin_oe  = oe_t & ~oe_pin_n;
   assign fb      = pin_oe ? pin_out : pin_in;
   // register content that reproduces the pin level through the polarity stage
   assign pl_val  = cfg_pol ? pin_in : ~pin_in;
endmodule

// File: rtl/mc_cell.sv
`timescale 1ns/1ps
module mc_cell #(
   parameter int unsigned N_IN    = 4,
   parameter int unsigned N_DATA  = 4,
   parameter bit          CK_RISE = 1'b1,
   localparam int unsigned FUSE_W = (N_DATA + mc_pkg::N_CTL) * 2 * N_IN
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FUSE_W-1:0] cfg_fuse,
   input  logic              cfg_pol,
   input  logic [N_IN-1:0]   in_bus,
   input  logic              preload_n,
   input  logic              oe_pin_n,
   input  logic              pin_in,
   output logic              pin_out,
   output logic              pin_oe,
   output logic              fb
);
   import mc_pkg::*;

   if (N_IN < 1 || N_DATA < 1) begin : g_bad_cfg
      $error("mc_cell: N_IN and N_DATA must be at least 1");
   end

   logic                 sum_t;
   logic [N_CTL-1:0]     ctl;
   logic                 set_t, clr_t, ck_t, oe_t;
   logic                 st_q;
   logic                 pl_val;

   mc_array #(.N_IN(N_IN), .N_DATA(N_DATA)) u_arr (
      .fuse (cfg_fuse),
      .lits (in_bus),
      .sum  (sum_t),
      .ctl  (ctl)
   );

   assign set_t = ctl[C_SET];
   assign clr_t = ctl[C_CLR];
   assign ck_t  = ctl[C_CLK];
   assign oe_t  = ctl[C_OE];

   mc_state #(.CK_RISE(CK_RISE)) u_st (
      .clk       (clk),
      .rst_n     (rst_n),
      .d         (sum_t),
      .set_t     (set_t),
      .clr_t     (clr_t),
      .ck_t      (ck_t),
      .preload_n (preload_n),
      .pl_val    (pl_val),
      .q         (st_q)
   );

   mc_outpath u_out (
      .cfg_pol  (cfg_pol),
      .bypass   (set_t & clr_t),
      .sum      (sum_t),
      .q        (st_q),
      .oe_t     (oe_t),
      .oe_pin_n (oe_pin_n),
      .pin_in   (pin_in),
      .pin_out  (pin_out),
      .pin_oe   (pin_oe),
      .fb       (fb),
      .pl_val   (pl_val)
   );
endmodule

// File: rtl/mc_cell_chk.sv
`timescale 1ns/1ps
module mc_cell_chk (
   input logic clk,
   input logic rst_n,
   input logic cfg_pol,
   input logic preload_n,
   input logic oe_pin_n,
   input logic pin_in,
   input logic pin_out,
   input logic pin_oe,
   input logic fb,
   input logic set_t,
   input logic clr_t,
   input logic sum_t,
   input logic st_q
);
   // R10: register held at 0 during reset
   always @(posedge clk) begin
      if (!rst_n) begin
         p_reset_low_r10: assert (st_q == 1'b0);
      end
   end

   p_oe_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      oe_pin_n |-> !pin_oe);

   p_fb_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pin_oe |-> (fb == pin_out));

   p_fb_input_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_oe |-> (fb == pin_in));

   p_bypass_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (set_t && clr_t) |-> (pin_out == (cfg_pol ? sum_t : ~sum_t)));

   p_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (preload_n && set_t && !clr_t) |=> st_q);

   p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (preload_n && !set_t && clr_t) |=> !st_q);

   p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (preload_n && set_t && clr_t) |=> $stable(st_q));

   p_preload_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !preload_n |=> (st_q == $past(cfg_pol ? pin_in : ~pin_in)));
endmodule

bind mc_cell mc_cell_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_pol   (cfg_pol),
   .preload_n (preload_n),
   .oe_pin_n  (oe_pin_n),
   .pin_in    (pin_in),
   .pin_out   (pin_out),
   .pin_oe    (pin_oe),
   .fb        (fb),
   .set_t     (set_t),
   .clr_t     (clr_t),
   .sum_t     (sum_t),
   .st_q      (st_q)
);

// File: tb/sim_mc_cell.sv
`timescale 1ns/1ps
module sim_mc_cell;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [63:0] fuse;
   logic        pol;
   logic [3:0]  inb;
   logic        preload_n;
   logic        oe_pin_n;
   logic        pin_in;
   logic        pin_out, pin_oe, fb;

   int n_cmp = 0;
   int n_bad = 0;

   always #4 clk = ~clk;   // 125 MHz

   mc_cell u0 (
      .clk(clk), .rst_n(rst_n), .cfg_fuse(fuse), .cfg_pol(pol),
      .in_bus(inb), .preload_n(preload_n), .oe_pin_n(oe_pin_n),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .fb(fb)
   );

   // Fuse layout: byte t = term t (0..3 data, 4 set, 5 clear, 6 clock, 7 enable);
   // bit 2i = in[i] true, bit 2i+1 = in[i] complement.
   localparam logic [63:0] F_A = 64'h00FF0000FFFF6005; // d0=in0&in1, d1=~in2&in3, bypass
   localparam logic [63:0] F_B = 64'h80FF0000FFFFFF00; // d0 const 1, enable=~in3, bypass
   localparam logic [63:0] F_C = 64'hFFFF0000FFFFFFFF; // all data const 0, enable const 0
   localparam logic [63:0] F_D = 64'h00FF000004FFFFFF; // d3=in1, bypass
   localparam logic [63:0] F_R = 64'h0040FFFFFFFFFF01; // registered: d0=in0, clock=in3
   localparam logic [63:0] F_S = 64'h00400410FFFFFF01; // plus set=in2, clear=in1

   typedef struct packed {
      logic [63:0] fz;
      logic [3:0]  in;
      logic        pol;
      logic        oen;
      logic        e_pin;
      logic        e_oe;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VT [NV] = '{
      '{F_A, 4'b0011, 1'b1, 1'b0, 1'b1, 1'b1},  // R2 first term true
      '{F_A, 4'b1000, 1'b1, 1'b0, 1'b1, 1'b1},  // R2 second term true
      '{F_A, 4'b0100, 1'b1, 1'b0, 1'b0, 1'b1},  // R2 none true
      '{F_A, 4'b1100, 1'b0, 1'b0, 1'b1, 1'b1},  // R6 inverted zero
      '{F_A, 4'b0011, 1'b0, 1'b0, 1'b0, 1'b1},  // R6 inverted one
      '{F_A, 4'b0011, 1'b1, 1'b1, 1'b1, 1'b0},  // R7 external disable
      '{F_B, 4'b0000, 1'b1, 1'b0, 1'b1, 1'b1},  // R1 empty term high, R7 term on
      '{F_B, 4'b1000, 1'b1, 1'b0, 1'b1, 1'b0},  // R7 term off
      '{F_B, 4'b1000, 1'b0, 1'b0, 1'b0, 1'b0},  // R6 with driver off
      '{F_C, 4'b0101, 1'b1, 1'b0, 1'b0, 1'b0},  // R1 full term low
      '{F_C, 4'b0101, 1'b0, 1'b0, 1'b1, 1'b0},  // R1 full term low, inverted
      '{F_D, 4'b0010, 1'b1, 1'b0, 1'b1, 1'b1},  // R2 last data term
      '{F_D, 4'b1101, 1'b1, 1'b0, 1'b0, 1'b1}   // R2 last data term false
   };

   task automatic chk(input string req, input logic got, input logic exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0b expected %0b", req, got, exp);
      end
   endtask

   // one rising edge between drive (at falling edge) and check
   task automatic step();
      @(negedge clk);
      #1;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; fuse = F_R; pol = 1'b0; inb = 4'b0000;
      preload_n = 1'b1; oe_pin_n = 1'b0; pin_in = 1'b0;
      repeat (2) @(negedge clk);
      #1;
      chk("R10 reset active-low pin", pin_out, 1'b1);
      chk("R7 reset driver on", pin_oe, 1'b1);
      pol = 1'b1; #1;
      chk("R10 reset active-high pin", pin_out, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;

      // bypass-mode vector table (combinational, no edge before check)
      for (int k = 0; k < NV; k++) begin
         @(negedge clk);
         fuse = VT[k].fz; inb = VT[k].in; pol = VT[k].pol; oe_pin_n = VT[k].oen;
         pin_in = ~VT[k].in[0];
         #1;
         chk("R3/R2/R6 table pin_out", pin_out, VT[k].e_pin);
         chk("R7 table pin_oe", pin_oe, VT[k].e_oe);
         chk("R8 table fb", fb, VT[k].e_oe ? VT[k].e_pin : ~VT[k].in[0]);
      end

      // R4 clock term edge behaviour
      @(negedge clk);
      fuse = F_R; pol = 1'b1; oe_pin_n = 1'b0; inb = 4'b0001;
      step(); chk("R4 no load while clock term low", pin_out, 1'b0);
      inb = 4'b1001;
      step(); chk("R4 load on clock term rise", pin_out, 1'b1);
      inb = 4'b1000;
      step(); chk("R4 no load with clock term held", pin_out, 1'b1);
      inb = 4'b0000;
      step(); chk("R4 no load on clock term fall", pin_out, 1'b1);
      inb = 4'b1000;
      step(); chk("R4 load zero on second rise", pin_out, 1'b0);

      // R5 set / clear
      fuse = F_S; inb = 4'b0100;
      step(); chk("R5 set", pin_out, 1'b1);
      inb = 4'b0010;
      step(); chk("R5 clear", pin_out, 1'b0);
      inb = 4'b1100;
      step(); chk("R5 set beats clock rise", pin_out, 1'b1);

      // R3 bypass follows data at once, R11 register holds
      inb = 4'b0111; #1;
      chk("R3 bypass shows data one", pin_out, 1'b1);
      inb = 4'b0110; #1;
      chk("R3 bypass shows data zero", pin_out, 1'b0);
      @(negedge clk);
      inb = 4'b0000; #1;
      chk("R11 register held through set+clear", pin_out, 1'b1);

      // R9 preload
      fuse = F_R; pol = 1'b0; pin_in = 1'b1; preload_n = 1'b0;
      step(); chk("R9 preload inverted polarity", pin_out, 1'b1);
      pol = 1'b1; pin_in = 1'b1; inb = 4'b1000;
      step(); chk("R9 preload beats clock rise", pin_out, 1'b1);
      preload_n = 1'b1; inb = 4'b0000;
      step(); chk("R9 preloaded value kept", pin_out, 1'b1);

      // R10 reset in mid-run
      rst_n = 1'b0; #1;
      chk("R10 mid-run reset active-high", pin_out, 1'b0);
      pol = 1'b0; #1;
      chk("R10 mid-run reset active-low", pin_out, 1'b1);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule